// File: doc/BRIEF.md
# Phase-Programmable Coarse Clock Divider

This block runs on a fast reference clock and divides it by 8 and by 16 with one free-running 4-bit counter that both outputs share. Each divided clock has its own coarse phase code, which moves both of its edges in steps of one reference period. The range of each code spans its whole output period, so with a 640 MHz reference the divide-by-16 output can be placed anywhere in its 25 ns period in 1.5625 ns steps. A copy of the reference clock is passed straight through for downstream logic.

Phase codes are written one channel at a time as an 8-bit word. The upper nibble is the coarse code. The lower nibble is held for a later fine-delay stage and is only carried through. A written code is first staged. It becomes active, together with its fine nibble, only when the shared counter wraps, so a change never shortens a high or low phase in the middle of a period. Both divided outputs come from registers on the reference clock.

Top module: `clkdiv_phase`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the counter to 0 and clears every staged and active code. On the first edge after reset, `div16_o` and `div8_o` are both 1 and both fine outputs are 0.
- R2: With counter value c and active slow coarse code p (4 bits), `div16_o` is 1 exactly when (c − p) mod 16 < 8. This gives a period of 16 reference cycles and a 50% duty cycle.
- R3: With active fast coarse code q (3 bits), `div8_o` is 1 exactly when (c mod 8 − q) mod 8 < 4. This gives a period of 8 reference cycles and a 50% duty cycle.
- R4: A write with `cfg_sel`=0 stages `cfg_word[7:4]` as the slow coarse code. A write with `cfg_sel`=1 stages `cfg_word[6:4]` as the fast coarse code, and `cfg_word[7]` has no effect on that channel.
- R5: The counter increments by one on every edge and wraps from 15 to 0. Staged codes are copied to the active codes only on the edge where the counter goes from 15 to 0. A write made while the counter reads 15 takes effect at the following wrap, not the current one.
- R6: `fine16_o` and `fine8_o` carry `cfg_word[3:0]` of the last write to their channel. They change together with that channel's coarse code, at a counter wrap.
- R7: A write to one channel leaves the other channel's output and fine code unchanged.
- R8: `ref_o` is a copy of `clk_ref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for a phase word |
| cfg_sel | input | 1 | Target channel: 0 = divide-by-16, 1 = divide-by-8 |
| cfg_word | input | 8 | Phase word: [7:4] coarse, [3:0] fine |
| ref_o | output | 1 | Copy of the reference clock |
| div16_o | output | 1 | Divide-by-16 clock, phase-shifted |
| div8_o | output | 1 | Divide-by-8 clock, phase-shifted |
| fine16_o | output | 4 | Active fine code of the divide-by-16 channel |
| fine8_o | output | 4 | Active fine code of the divide-by-8 channel |

## Verification
Several properties are checked on every cycle: the counter steps by one, the reset state is reached, active coarse and fine codes change only at a counter wrap, and each output sits on its counter phase whenever its code is zero. The rest can only be shown by the bench's scenarios, which compare every output against a reference model computed from the rules above. These cover the output waveform for nonzero phases, the bit-7 rule of the fast channel, a write landing on count 15, and the isolation between channels. Random writes and occasional resets exercise codes across their full range, including the extreme values 15 and 7.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic {
        CH_SLOW = 1'b0,
        CH_FAST = 1'b1
    } chan_sel_e;
endpackage

// File: rtl/ckd_counter.sv
module ckd_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cnt_o      = s_q.cnt;
    assign cnt_next_o = s_d.cnt;
    assign wrap_o     = (s_q.cnt == {W{1'b1}});
endmodule

// File: rtl/ckd_cfg.sv
module ckd_cfg
    import clkdiv_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int FAST_W = 3,
    parameter int FINE_W = 4,
    localparam int WORD_W = CNT_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  slow_coarse_o,
    output logic [FINE_W-1:0] slow_fine_o,
    output logic [FAST_W-1:0] fast_coarse_o,
    output logic [FINE_W-1:0] fast_fine_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  slow_coarse;
        logic [FINE_W-1:0] slow_fine;
        logic [FAST_W-1:0] fast_coarse;
        logic [FINE_W-1:0] fast_fine;
    } state_t;

    state_t    s_d, s_q;
    chan_sel_e tgt;

    assign tgt = chan_sel_e'(sel);

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d = '0;
        end else if (wr) begin
            if (tgt == CH_SLOW) begin
                s_d.slow_coarse = word[WORD_W-1:FINE_W];
                s_d.slow_fine   = word[FINE_W-1:0];
            end else begin
                s_d.fast_coarse = word[FINE_W+FAST_W-1:FINE_W];
                s_d.fast_fine   = word[FINE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign slow_coarse_o = s_q.slow_coarse;
    assign slow_fine_o   = s_q.slow_fine;
    assign fast_coarse_o = s_q.fast_coarse;
    assign fast_fine_o   = s_q.fast_fine;
endmodule

// File: rtl/ckd_phase_chan.sv
module ckd_phase_chan #(
    parameter int CODE_W = 4,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic [CODE_W-1:0] cnt_next,
    input  logic [CODE_W-1:0] pend_coarse,
    input  logic [FINE_W-1:0] pend_fine,
    output logic              clk_o,
    output logic [CODE_W-1:0] coarse_o,
    output logic [FINE_W-1:0] fine_o
);
    typedef struct packed {
        logic [CODE_W-1:0] coarse;
        logic [FINE_W-1:0] fine;
        logic              level;
    } state_t;

    state_t            s_d, s_q;
    logic [CODE_W-1:0] offset;

    always_comb begin
        s_d    = s_q;
        offset = '0;
        if (rst) begin
            s_d.coarse = '0;
            s_d.fine   = '0;
            s_d.level  = 1'b1;
        end else begin
            if (wrap) begin
                s_d.coarse = pend_coarse;
                s_d.fine   = pend_fine;
            end
            offset    = cnt_next - s_d.coarse;
            s_d.level = ~offset[CODE_W-1];
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign clk_o    = s_q.level;
    assign coarse_o = s_q.coarse;
    assign fine_o   = s_q.fine;
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int CNT_W  = 4,
    parameter int FAST_W = 3,
    parameter int FINE_W = 4,
    localparam int WORD_W = CNT_W + FINE_W
) (
    input  logic              clk_ref,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              ref_o,
    output logic              div16_o,
    output logic              div8_o,
    output logic [FINE_W-1:0] fine16_o,
    output logic [FINE_W-1:0] fine8_o
);
    logic [CNT_W-1:0]  cnt_now;
    logic [CNT_W-1:0]  cnt_next;
    logic              wrap;
    logic [CNT_W-1:0]  pend_slow_c;
    logic [FINE_W-1:0] pend_slow_f;
    logic [FAST_W-1:0] pend_fast_c;
    logic [FINE_W-1:0] pend_fast_f;
    logic [CNT_W-1:0]  act_slow_c;
    logic [FAST_W-1:0] act_fast_c;

    assign ref_o = clk_ref;

    ckd_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk_ref),
        .rst        (rst),
        .cnt_o      (cnt_now),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    ckd_cfg #(.CNT_W(CNT_W), .FAST_W(FAST_W), .FINE_W(FINE_W)) u_cfg (
        .clk           (clk_ref),
        .rst           (rst),
        .wr            (cfg_wr),
        .sel           (cfg_sel),
        .word          (cfg_word),
        .slow_coarse_o (pend_slow_c),
        .slow_fine_o   (pend_slow_f),
        .fast_coarse_o (pend_fast_c),
        .fast_fine_o   (pend_fast_f)
    );

    ckd_phase_chan #(.CODE_W(CNT_W), .FINE_W(FINE_W)) u_slow (
        .clk         (clk_ref),
        .rst         (rst),
        .wrap        (wrap),
        .cnt_next    (cnt_next),
        .pend_coarse (pend_slow_c),
        .pend_fine   (pend_slow_f),
        .clk_o       (div16_o),
        .coarse_o    (act_slow_c),
        .fine_o      (fine16_o)
    );

    ckd_phase_chan #(.CODE_W(FAST_W), .FINE_W(FINE_W)) u_fast (
        .clk         (clk_ref),
        .rst         (rst),
        .wrap        (wrap),
        .cnt_next    (cnt_next[FAST_W-1:0]),
        .pend_coarse (pend_fast_c),
        .pend_fine   (pend_fast_f),
        .clk_o       (div8_o),
        .coarse_o    (act_fast_c),
        .fine_o      (fine8_o)
    );
endmodule

// File: rtl/clkdiv_phase_chk.sv
module clkdiv_phase_chk #(
    parameter int CNT_W  = 4,
    parameter int FAST_W = 3,
    parameter int FINE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_slow,
    input logic [FAST_W-1:0] act_fast,
    input logic [FINE_W-1:0] fine16,
    input logic [FINE_W-1:0] fine8,
    input logic              div16,
    input logic              div8
);
    localparam logic [CNT_W-1:0]  CNT_TOP   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  SLOW_HALF = CNT_W'(1) << (CNT_W - 1);
    localparam logic [FAST_W-1:0] FAST_HALF = FAST_W'(1) << (FAST_W - 1);

    logic armed_q = 1'b0;
    logic rst_q   = 1'b0;

    always_ff @(posedge clk) begin
        armed_q <= ~rst;
        rst_q   <= rst;
    end

    // R1: reset state reached
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (cnt == '0 && act_slow == '0 && act_fast == '0 &&
                   fine16 == '0 && fine8 == '0 && div16 && div8));

    // R5: counter steps by one
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> cnt == $past(cnt) + 1'b1);

    // R5: active coarse codes move only at wrap
    p_coarse_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (armed_q && (!$stable(act_slow) || !$stable(act_fast))) |-> $past(cnt) == CNT_TOP);

    // R6: fine codes move only at wrap
    p_fine_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (armed_q && (!$stable(fine16) || !$stable(fine8))) |-> $past(cnt) == CNT_TOP);

    // R2: zero slow phase aligns with counter
    p_slow_zero_align_r2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && act_slow == '0) |-> div16 == (cnt < SLOW_HALF));

    // R3: zero fast phase aligns with counter
    p_fast_zero_align_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && act_fast == '0) |-> div8 == (cnt[FAST_W-1:0] < FAST_HALF));
endmodule

bind clkdiv_phase clkdiv_phase_chk #(
    .CNT_W  (CNT_W),
    .FAST_W (FAST_W),
    .FINE_W (FINE_W)
) u_chk (
    .clk      (clk_ref),
    .rst      (rst),
    .cnt      (cnt_now),
    .act_slow (act_slow_c),
    .act_fast (act_fast_c),
    .fine16   (fine16_o),
    .fine8    (fine8_o),
    .div16    (div16_o),
    .div8     (div8_o)
);

// File: tb/clkdiv_phase_tb.sv
module clkdiv_phase_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_word = 8'h00;
    logic       ref_o, div16_o, div8_o;
    logic [3:0] fine16_o, fine8_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt = 0;
    int m_ps = 0, m_pf = 0, m_psf = 0, m_pff = 0;
    int m_as = 0, m_af = 0, m_asf = 0, m_aff = 0;

    clkdiv_phase u_dut (
        .clk_ref  (clk_ref),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_word (cfg_word),
        .ref_o    (ref_o),
        .div16_o  (div16_o),
        .div8_o   (div8_o),
        .fine16_o (fine16_o),
        .fine8_o  (fine8_o)
    );

    always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

    function automatic int exp_slow(int c, int p);
        return (((c - p) & 15) < 8) ? 1 : 0;
    endfunction

    function automatic int exp_fast(int c, int p);
        return ((((c & 7) - p) & 7) < 4) ? 1 : 0;
    endfunction

    task automatic check(bit ok, string req, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_cnt = 0; m_ps = 0; m_pf = 0; m_psf = 0; m_pff = 0;
            m_as = 0; m_af = 0; m_asf = 0; m_aff = 0;
        end else begin
            if (m_cnt == 15) begin
                m_as = m_ps; m_asf = m_psf; m_af = m_pf; m_aff = m_pff;
            end
            if (cfg_wr) begin
                if (!cfg_sel) begin
                    m_ps = int'(cfg_word[7:4]); m_psf = int'(cfg_word[3:0]);
                end else begin
                    m_pf = int'(cfg_word[6:4]); m_pff = int'(cfg_word[3:0]);
                end
            end
            m_cnt = (m_cnt + 1) & 15;
        end
    endtask

    task automatic compare(string tag);
        int e16, e8;
        e16 = exp_slow(m_cnt, m_as);
        e8  = exp_fast(m_cnt, m_af);
        check(int'(div16_o) == e16, "R2", tag, int'(div16_o), e16);
        check(int'(div8_o) == e8, "R3", tag, int'(div8_o), e8);
        check(int'(fine16_o) == m_asf, "R6", tag, int'(fine16_o), m_asf);
        check(int'(fine8_o) == m_aff, "R6", tag, int'(fine8_o), m_aff);
    endtask

    // one reference cycle: inputs set after a falling edge, checked at the next one
    task automatic cyc(bit r, bit w, bit s, logic [7:0] wd, string tag);
        rst = r; cfg_wr = w; cfg_sel = s; cfg_word = wd;
        @(posedge clk_ref);
        #1;
        model_step();
        @(negedge clk_ref);
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic run_to(int c, string tag);
        while (m_cnt != c) cyc(1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk_ref);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int sv_div8;
        void'($urandom(32'h5eed_1234));
        @(negedge clk_ref);

        // R1: reset state
        cyc(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        cyc(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        check(div16_o == 1'b1, "R1", "reset", int'(div16_o), 1);
        check(div8_o == 1'b1, "R1", "reset", int'(div8_o), 1);
        check(fine16_o == 4'd0 && fine8_o == 4'd0, "R1", "reset",
              int'({fine16_o, fine8_o}), 0);

        // R8: pass-through of the reference clock
        check(ref_o == 1'b0, "R8", "low half", int'(ref_o), 0);
        @(posedge clk_ref);
        #(CLK_PERIOD / 4);
        check(ref_o == 1'b1, "R8", "high half", int'(ref_o), 1);
        @(negedge clk_ref);

        // zero phases, two full periods
        idle(32, "zero phase");

        // R5: write slow mid-period, old phase holds until wrap
        run_to(3, "R5");
        cyc(1'b0, 1'b1, 1'b0, 8'h35, "R5");
        idle(20, "R5");

        // R4 and R7: fast write with bit 7 set, slow untouched
        run_to(6, "R7");
        cyc(1'b0, 1'b1, 1'b1, 8'hA2, "R4");
        idle(18, "R7");
        check(int'(fine16_o) == 5, "R7", "slow fine kept", int'(fine16_o), 5);
        check(int'(fine8_o) == 2, "R4", "fast fine", int'(fine8_o), 2);

        // R5: write on count 15 waits one more wrap
        run_to(15, "R5");
        cyc(1'b0, 1'b1, 1'b0, 8'hF9, "R5");
        check(int'(fine16_o) == 5, "R5", "count-15 write not yet applied",
              int'(fine16_o), 5);
        idle(15, "R5");
        check(int'(fine16_o) == 5, "R5", "before next wrap", int'(fine16_o), 5);
        idle(2, "R5");
        check(int'(fine16_o) == 9, "R5", "after next wrap", int'(fine16_o), 9);

        // boundary codes: slow 15, fast 7
        run_to(2, "boundary");
        cyc(1'b0, 1'b1, 1'b1, 8'h7C, "boundary");
        idle(34, "boundary");

        // R7: slow write leaves fast output alone
        run_to(4, "R7");
        sv_div8 = int'(fine8_o);
        cyc(1'b0, 1'b1, 1'b0, 8'h81, "R7");
        idle(20, "R7");
        check(int'(fine8_o) == sv_div8, "R7", "fast fine kept", int'(fine8_o), sv_div8);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit r, w, s;
            logic [7:0] wd;
            r  = (($urandom % 250) == 0);
            w  = (($urandom % 4) == 0);
            s  = 1'($urandom % 2);
            wd = 8'($urandom);
            cyc(r, w, s, wd, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule